// File: doc/BRIEF.md
# Palette-Indexed Splash Blitter

This engine paints a boot splash into a 16-bit-per-pixel framebuffer through a single write port. A run begins with a start strobe. The engine first floods the whole screen area with one background colour. That colour is the palette entry chosen by the top-left index of the stored image. It then copies the stored indexed image into the bottom-right corner of the screen. Each 8-bit index is turned into an RGB565 word by the palette on the way out.

The image indices and the palette sit in two internal memories. Each memory has its own load port. Screen geometry, line pitch in bytes, framebuffer base and image size are sampled when a run is accepted. A valid/ready handshake paces every framebuffer write, and a one-cycle done pulse closes the run.

Top module: `splash_blit`

## Requirements
- R1: After reset, `wr_valid`, `busy` and `done` are all low.
- R2: Every background write carries the palette word selected by image index 0, sampled when the run is accepted.
- R3: Background writes go to byte addresses base, base+2, base+4 and so on, in rising order. There are pitch×screen_height/2 of them. The base is even and the pitch is even.
- R4: All background writes are issued before the first image write.
- R5: The image pixel at column x and row y is written to base + pitch×(y + sh − ih) + 2×(x + sw − iw). Writes go in raster order, with x advancing fastest.
- R6: The data for image pixel (x, y) is the palette word at the index stored at image location x + y×iw.
- R7: While `wr_valid` is high and `wr_ready` is low, the next cycle keeps `wr_valid` high and `wr_addr`/`wr_data` unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the last accepted write. `busy` is low in that cycle.
- R9: A start strobe is accepted only when `busy` and `done` are both low. Strobes and changes of geometry inputs outside that window have no effect on the writes produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request strobe |
| fb_base | input | 24 | Framebuffer byte base address (even) |
| scr_w | input | 11 | Screen width in pixels |
| scr_h | input | 11 | Screen height in lines |
| pitch | input | 13 | Line pitch in bytes (even) |
| img_w | input | 11 | Image width, 1..scr_w |
| img_h | input | 11 | Image height, 1..scr_h |
| idx_we | input | 1 | Image index memory write enable |
| idx_waddr | input | 10 | Image index memory write address |
| idx_wdata | input | 8 | Image index value |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 8 | Palette write address |
| pal_wdata | input | 16 | Palette RGB565 word |
| wr_valid | output | 1 | Framebuffer write request |
| wr_ready | input | 1 | Framebuffer accepts the write |
| wr_addr | output | 24 | Framebuffer byte address |
| wr_data | output | 16 | RGB565 pixel word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two events coincide on a single clock edge. The last background handshake both ends the flood and loads the first image address. A back-pressure stall can fall on exactly that word. The bench drives a pseudo-random ready pattern so stalls land on phase boundaries and row ends. A scoreboard then requires every write to appear once, in order, with the right address and data. A second start strobe is also placed mid-run, and another in the done cycle, each together with altered geometry inputs. Both must leave the write stream untouched and must not restart the engine.

// File: rtl/splash_pkg.sv
package splash_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_FILL = 2'd1,
    S_IMG  = 2'd2,
    S_DONE = 2'd3
  } blit_st_e;

  localparam int unsigned PIX_W = 16;
  localparam int unsigned IDX_W = 8;
endpackage

// File: rtl/splash_ram.sv
module splash_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/splash_seq.sv
module splash_seq
  import splash_pkg::*;
#(
  parameter int unsigned AW  = 24,
  parameter int unsigned CW  = 11,
  parameter int unsigned PW  = 13,
  parameter int unsigned BAW = 10,
  localparam int unsigned NW = PW + CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    fb_base,
  input  logic [CW-1:0]    scr_w,
  input  logic [CW-1:0]    scr_h,
  input  logic [PW-1:0]    pitch,
  input  logic [CW-1:0]    img_w,
  input  logic [CW-1:0]    img_h,
  input  logic [PIX_W-1:0] pix_col,
  output logic [BAW-1:0]   src_idx,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  output logic             busy,
  output logic             done
);
  blit_st_e         st_q, st_d;
  logic [AW-1:0]    addr_q, addr_d, row_q, row_d;
  logic [PW-1:0]    pitch_q, pitch_d;
  logic [CW-1:0]    iw_q, iw_d, ih_q, ih_d, x_q, x_d, y_q, y_d;
  logic [NW-1:0]    cnt_q, cnt_d;
  logic [BAW-1:0]   src_q, src_d;
  logic [PIX_W-1:0] fcol_q, fcol_d;
  logic             fire;
  logic [NW-1:0]    area_bytes;
  logic [AW-1:0]    corner;

  assign fire       = wr_valid && wr_ready;
  assign area_bytes = NW'(pitch) * NW'(scr_h);
  assign corner     = fb_base + AW'(pitch) * AW'(scr_h - img_h)
                    + AW'({scr_w - img_w, 1'b0});

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    row_d   = row_q;
    pitch_d = pitch_q;
    iw_d    = iw_q;
    ih_d    = ih_q;
    x_d     = x_q;
    y_d     = y_q;
    cnt_d   = cnt_q;
    src_d   = src_q;
    fcol_d  = fcol_q;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d    = S_FILL;
          addr_d  = fb_base;
          row_d   = corner;
          pitch_d = pitch;
          iw_d    = img_w;
          ih_d    = img_h;
          cnt_d   = area_bytes >> 1;
          fcol_d  = pix_col;
          src_d   = '0;
        end
      end
      S_FILL: begin
        if (fire) begin
          if (cnt_q == NW'(1)) begin
            st_d   = S_IMG;
            addr_d = row_q;
            x_d    = '0;
            y_d    = '0;
            src_d  = '0;
          end else begin
            addr_d = addr_q + AW'(2);
          end
          cnt_d = cnt_q - NW'(1);
        end
      end
      S_IMG: begin
        if (fire) begin
          src_d = src_q + BAW'(1);
          if (x_q == iw_q - CW'(1)) begin
            x_d = '0;
            if (y_q == ih_q - CW'(1)) begin
              st_d  = S_DONE;
              src_d = '0;
            end else begin
              y_d    = y_q + CW'(1);
              row_d  = row_q + AW'(pitch_q);
              addr_d = row_q + AW'(pitch_q);
            end
          end else begin
            x_d    = x_q + CW'(1);
            addr_d = addr_q + AW'(2);
          end
        end
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      row_q   <= '0;
      pitch_q <= '0;
      iw_q    <= '0;
      ih_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      cnt_q   <= '0;
      src_q   <= '0;
      fcol_q  <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      row_q   <= row_d;
      pitch_q <= pitch_d;
      iw_q    <= iw_d;
      ih_q    <= ih_d;
      x_q     <= x_d;
      y_q     <= y_d;
      cnt_q   <= cnt_d;
      src_q   <= src_d;
      fcol_q  <= fcol_d;
    end
  end

  assign src_idx  = src_q;
  assign wr_valid = (st_q == S_FILL) || (st_q == S_IMG);
  assign wr_addr  = addr_q;
  assign wr_data  = (st_q == S_FILL) ? fcol_q : pix_col;
  assign busy     = wr_valid;
  assign done     = (st_q == S_DONE);

  // R7: a refused write is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: addresses stay on pixel boundaries
  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[0] == 1'b0));
  // R2: background colour constant across the flood
  p_fill_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL && $past(st_q) == S_FILL) |-> $stable(wr_data));
  // R4: no return to the flood once copying began
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IMG) |=> (st_q != S_FILL));
  // R9: captured geometry frozen during a run
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |=> ($stable(pitch_q) && $stable(iw_q) && $stable(ih_q)));
endmodule

// File: rtl/splash_blit.sv
module splash_blit
  import splash_pkg::*;
#(
  parameter int unsigned AW  = 24,
  parameter int unsigned CW  = 11,
  parameter int unsigned PW  = 13,
  parameter int unsigned BAW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    fb_base,
  input  logic [CW-1:0]    scr_w,
  input  logic [CW-1:0]    scr_h,
  input  logic [PW-1:0]    pitch,
  input  logic [CW-1:0]    img_w,
  input  logic [CW-1:0]    img_h,
  input  logic             idx_we,
  input  logic [BAW-1:0]   idx_waddr,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             pal_we,
  input  logic [IDX_W-1:0] pal_waddr,
  input  logic [PIX_W-1:0] pal_wdata,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  output logic             busy,
  output logic             done
);
  logic [1:0]       rsync_q;
  logic             core_rst_n;
  logic [BAW-1:0]   src_idx;
  logic [IDX_W-1:0] idx_val;
  logic [PIX_W-1:0] pix_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  splash_ram #(.DW(IDX_W), .AW(BAW)) u_idx_ram (
    .clk(clk), .we(idx_we), .waddr(idx_waddr), .wdata(idx_wdata),
    .raddr(src_idx), .rdata(idx_val)
  );

  splash_ram #(.DW(PIX_W), .AW(IDX_W)) u_pal_ram (
    .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
    .raddr(idx_val), .rdata(pix_col)
  );

  splash_seq #(.AW(AW), .CW(CW), .PW(PW), .BAW(BAW)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .start(start),
    .fb_base(fb_base), .scr_w(scr_w), .scr_h(scr_h), .pitch(pitch),
    .img_w(img_w), .img_h(img_h), .pix_col(pix_col), .src_idx(src_idx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  // R1: quiet while the synchronised reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !core_rst_n |-> (!wr_valid && !busy && !done));
endmodule

// File: tb/tb_splash_blit.sv
module tb_splash_blit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] fb_base = '0;
  logic [10:0] scr_w = '0, scr_h = '0, img_w = '0, img_h = '0;
  logic [12:0] pitch = '0;
  logic        idx_we = 1'b0, pal_we = 1'b0;
  logic [9:0]  idx_waddr = '0;
  logic [7:0]  idx_wdata = '0, pal_waddr = '0;
  logic [15:0] pal_wdata = '0;
  logic        wr_valid, wr_ready = 1'b1, busy, done;
  logic [23:0] wr_addr;
  logic [15:0] wr_data;

  int tests = 0, fails = 0, cyc = 0, last_fire = -10;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0]  idx_m [1024];
  logic [15:0] pal_m [256];

  typedef struct { logic [23:0] a; logic [15:0] d; string ta; string td; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  splash_blit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_base(fb_base),
    .scr_w(scr_w), .scr_h(scr_h), .pitch(pitch), .img_w(img_w), .img_h(img_h),
    .idx_we(idx_we), .idx_waddr(idx_waddr), .idx_wdata(idx_wdata),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
  end

  logic        hold_p = 1'b0;
  logic [23:0] hold_a;
  logic [15:0] hold_d;
  always @(negedge clk) begin
    if (hold_p) begin
      chk(wr_valid && wr_addr == hold_a && wr_data == hold_d, "R7 stall hold",
          int'(wr_addr), int'(hold_a));
    end
    hold_p = wr_valid && !wr_ready;
    hold_a = wr_addr;
    hold_d = wr_data;
    if (wr_valid && wr_ready) begin
      last_fire = cyc;
      if (q.size() == 0) begin
        chk(1'b0, "R9 unexpected write", int'(wr_addr), 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(wr_addr == it.a, it.ta, int'(wr_addr), int'(it.a));
        chk(wr_data == it.d, it.td, int'(wr_data), int'(it.d));
      end
    end
  end

  task automatic run(input int base, input int sw, input int sh, input int pit,
                     input int iw, input int ih, input bit poke);
    int xs, ys, dcyc;
    xs = sw - iw;
    ys = sh - ih;
    for (int k = 0; k < pit * sh / 2; k++) begin
      item_t it;
      it.a = 24'(base + 2 * k);
      it.d = pal_m[idx_m[0]];
      it.ta = "R3 R4 fill address";
      it.td = "R2 fill colour";
      q.push_back(it);
    end
    for (int y = 0; y < ih; y++) begin
      for (int x = 0; x < iw; x++) begin
        item_t it;
        it.a = 24'(base + pit * (y + ys) + 2 * (x + xs));
        it.d = pal_m[idx_m[x + y * iw]];
        it.ta = "R5 image address";
        it.td = "R6 image colour";
        q.push_back(it);
      end
    end
    @(negedge clk);
    fb_base = 24'(base); scr_w = 11'(sw); scr_h = 11'(sh);
    pitch = 13'(pit); img_w = 11'(iw); img_h = 11'(ih);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(busy, "R9 busy during run", int'(busy), 1);
      fb_base = 24'h0F0000; pitch = 13'd2; img_w = 11'd1; img_h = 11'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    dcyc = cyc;
    chk(dcyc == last_fire + 1, "R8 done timing", dcyc, last_fire + 1);
    chk(!busy && !wr_valid, "R8 idle at done", int'(busy), 0);
    chk(q.size() == 0, "R5 all writes seen", q.size(), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R8 done one cycle", int'(done), 0);
    chk(!busy, "R9 start in done cycle ignored", int'(busy), 0);
    repeat (8) @(negedge clk);
    chk(!busy && !wr_valid, "R9 no restart", int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) idx_m[i] = 8'((i * 7 + 3) & 255);
    for (int j = 0; j < 256; j++) pal_m[j] = 16'((j * 16'h0123) ^ 16'h5A5A);
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !done, "R1 reset state", int'({wr_valid, busy, done}), 0);
    for (int i = 0; i < 1024; i++) begin
      idx_we = 1'b1; idx_waddr = 10'(i); idx_wdata = idx_m[i];
      @(negedge clk);
    end
    idx_we = 1'b0;
    for (int j = 0; j < 256; j++) begin
      pal_we = 1'b1; pal_waddr = 8'(j); pal_wdata = pal_m[j];
      @(negedge clk);
    end
    pal_we = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_valid && !busy && !done, "R1 after release", int'({wr_valid, busy, done}), 0);

    ready_mode = 0;
    run(32'h100, 8, 4, 16, 3, 2, 1'b0);
    ready_mode = 1;
    run(32'h2000, 10, 6, 24, 4, 3, 1'b1);
    run(32'h40, 4, 3, 8, 4, 3, 1'b0);
    run(32'h800, 5, 5, 10, 1, 1, 1'b1);
    ready_mode = 0;
    run(32'h0, 6, 2, 12, 6, 1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule